// File: doc/BRIEF.md
# Flash Command Sequencer

This block issues one short serial-flash command at a time on behalf of software. Software loads an address word and up to two 32-bit write payload words, then writes a packed control word with its launch bit set. The engine hands the command to a byte-level serializer as a series of items: the opcode byte, then optional address bytes, then an optional dummy-clock item, then optional write bytes, and finally optional read bytes. Read bytes land in two 32-bit result words. While the command runs, the launch and in-progress bits of the control word read as one. They clear once the serializer has reported idle on enough consecutive cycles.

The sequencer is a state machine with these states: `ST_IDLE`, `ST_OPCODE`, `ST_ADDR`, `ST_DUMMY`, `ST_WDATA`, `ST_RDATA` and `ST_SETTLE`. Its transitions are as follows:
- A launch write moves the machine from `ST_IDLE` to `ST_OPCODE`.
- Each item state ends on the acknowledge of its last item. It then goes to the first later state whose phase is enabled, in the order address, dummy, write data, read data. If none is enabled, it goes to `ST_SETTLE`.
- `ST_SETTLE` returns to `ST_IDLE` once the idle filter reports the serializer settled.

Only one item is offered at a time. It stays on the item outputs until the serializer acknowledges it.

Register indices on the bus are:
- 0: control word.
- 1: command address.
- 2: write payload, lower word.
- 3: write payload, upper word.
- 4: read result, lower word (read-only).
- 5: read result, upper word (read-only).

Top module: `flcmd_engine`

## Requirements
- R1: After reset, every register reads zero, `sh_req` is low and no command is in progress.
- R2: Control word fields are: opcode [31:24], read enable [23], read count-1 [22:20], address enable [19], address length-1 [17:16], write enable [15], write count-1 [14:12], dummy clocks [11:7], in-progress [1], launch [0]. A control write with bit 0 set while idle starts a command. Bits [1] and [0] read 1 while the command runs and 0 once it ends; the other bits read back as written.
- R3: The first item of every command is a transmit item (`sh_kind` 0) that carries the opcode.
- R4: With address enable set, the engine sends length-1 plus 1 transmit items from the address register, most significant selected byte first (3 bytes: bits [23:16] first; 4 bytes: bits [31:24] first).
- R5: A non-zero dummy field produces exactly one dummy item (`sh_kind` 1) with `sh_cycles` equal to the field. A zero field produces no dummy item.
- R6: With write enable set, the engine sends count-1 plus 1 transmit bytes, ordered from payload byte 0 upward. Byte k is bits [8k+7:8k] of the lower word for k<4, and byte k-4 of the upper word for k>=4.
- R7: With read enable set, the engine issues count-1 plus 1 receive items (`sh_kind` 2). The byte returned for receive item k is stored at the same byte position as in R6, in the result words. Result bytes not filled by the command read as zero.
- R8: When both write and read are enabled, all write bytes go out before the first receive item.
- R9: After the last item, the command stays in progress until `ser_idle` has been high on IDLE_SAMPLES (3) consecutive clock edges. A low sample restarts the count.
- R10: A control write during a running command is ignored. The stored word is unchanged and no further command starts.
- R11: An offered item (`sh_req` high) keeps its kind, byte and cycle count stable until `sh_ack` is seen.
- R12: Bus writes to the result words (indices 4 and 5) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Register write index |
| bus_wdata | input | 32 | Register write data |
| bus_raddr | input | 3 | Register read index |
| bus_rdata | output | 32 | Register read data (combinational) |
| sh_req | output | 1 | Item offered to the serializer |
| sh_kind | output | 2 | Item kind: 0 transmit, 1 dummy, 2 receive |
| sh_byte | output | 8 | Byte to transmit (0 for other kinds) |
| sh_cycles | output | 5 | Dummy clock count for dummy items |
| sh_frame | output | 1 | High while command items are being offered |
| sh_ack | input | 1 | Serializer finished the offered item |
| sh_rx_byte | input | 8 | Received byte, valid with `sh_ack` on receive items |
| ser_idle | input | 1 | Serializer reports idle |

## Verification
Some properties are checked on every cycle by the assertions:
- An offered item stays stable until it is acknowledged.
- The opcode item is always first.
- The machine leaves idle only on a launch.
- A control write during a command leaves the stored word untouched.
- The idle filter only settles after idle runs.
- Short reads leave the upper result word zero.

Other behaviour only the bench's scenarios can show. This covers the exact item order and contents for each phase mix (3- and 4-byte addresses, dummy on and off, payload byte ordering, write-before-read), the placement of returned bytes, the restart of the idle count after a dropout, and that a rejected control write launches no extra items.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPCODE = 3'd1,
        ST_ADDR   = 3'd2,
        ST_DUMMY  = 3'd3,
        ST_WDATA  = 3'd4,
        ST_RDATA  = 3'd5,
        ST_SETTLE = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        ITEM_TX    = 2'd0,
        ITEM_DUMMY = 2'd1,
        ITEM_RX    = 2'd2
    } item_kind_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       rd_en;
        logic [2:0] rd_cnt_m1;
        logic       addr_en;
        logic       spare18;
        logic [1:0] addr_len_m1;
        logic       wr_en;
        logic [2:0] wr_cnt_m1;
        logic [4:0] dummy;
        logic [4:0] spare6_2;
        logic       running;
        logic       launch;
    } cmd_word_t;

    localparam logic [2:0] IDX_CTRL = 3'd0;
    localparam logic [2:0] IDX_ADDR = 3'd1;
    localparam logic [2:0] IDX_WLO  = 3'd2;
    localparam logic [2:0] IDX_WHI  = 3'd3;
    localparam logic [2:0] IDX_RLO  = 3'd4;
    localparam logic [2:0] IDX_RHI  = 3'd5;

endpackage

// File: rtl/flcmd_regs.sv
module flcmd_regs
    import flcmd_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_waddr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [2:0]        bus_raddr,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              cap_valid,
    input  logic [2:0]        cap_idx,
    input  logic [7:0]        cap_byte,
    output logic              start,
    output cmd_word_t         cmd,
    output logic [WORD_W-1:0] cmd_addr,
    output logic [2*WORD_W-1:0] wpay
);
    localparam int PAY_W = 2 * WORD_W;

    logic [WORD_W-1:0] ctrl_q, addr_q, wlo_q, whi_q;
    logic [PAY_W-1:0]  rd_q;
    logic              ctrl_wr_ok;

    assign ctrl_wr_ok = bus_wr && (bus_waddr == IDX_CTRL) && !busy;
    assign start      = ctrl_wr_ok && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            addr_q <= '0;
            wlo_q  <= '0;
            whi_q  <= '0;
        end else if (bus_wr) begin
            unique case (bus_waddr)
                IDX_CTRL: if (!busy) ctrl_q <= bus_wdata;
                IDX_ADDR: addr_q <= bus_wdata;
                IDX_WLO:  wlo_q  <= bus_wdata;
                IDX_WHI:  whi_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (start) begin
            rd_q <= '0;
        end else if (cap_valid) begin
            rd_q[{cap_idx, 3'b000} +: 8] <= cap_byte;
        end
    end

    always_comb begin
        unique case (bus_raddr)
            IDX_CTRL: bus_rdata = {ctrl_q[WORD_W-1:2], busy, busy};
            IDX_ADDR: bus_rdata = addr_q;
            IDX_WLO:  bus_rdata = wlo_q;
            IDX_WHI:  bus_rdata = whi_q;
            IDX_RLO:  bus_rdata = rd_q[WORD_W-1:0];
            IDX_RHI:  bus_rdata = rd_q[PAY_W-1:WORD_W];
            default:  bus_rdata = '0;
        endcase
    end

    assign cmd      = cmd_word_t'(ctrl_q);
    assign cmd_addr = addr_q;
    assign wpay     = {whi_q, wlo_q};

    // R10: control word frozen while a command runs
    a_r10_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_waddr == IDX_CTRL) |=> $stable(ctrl_q));

    // R7: a short read leaves the upper result word clear
    a_r7_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && ctrl_q[23] && ctrl_q[22:20] < 3'd4) |-> rd_q[PAY_W-1:WORD_W] == '0);

endmodule

// File: rtl/flcmd_idle_filt.sv
module flcmd_idle_filt #(
    parameter int IDLE_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic idle_in,
    output logic settled
);
    localparam int CW = $clog2(IDLE_SAMPLES + 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !arm || !idle_in)
            run_q <= '0;
        else if (run_q != CW'(IDLE_SAMPLES - 1))
            run_q <= run_q + 1'b1;
    end

    assign settled = arm && idle_in && (run_q == CW'(IDLE_SAMPLES - 1));

    generate
        if (IDLE_SAMPLES >= 2) begin : g_run_chk
            // R9: settling needs idle on the previous sample as well
            a_r9_idle_run: assert property (@(posedge clk) disable iff (!rst_n)
                settled |-> ($past(idle_in) && $past(arm)));
        end
    endgenerate

endmodule

// File: rtl/flcmd_seq.sv
module flcmd_seq
    import flcmd_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  cmd_word_t           cmd,
    input  logic [WORD_W-1:0]   cmd_addr,
    input  logic [2*WORD_W-1:0] wpay,
    input  logic                sh_ack,
    input  logic [7:0]          sh_rx_byte,
    input  logic                settled,
    output logic                busy,
    output logic                arm,
    output logic                sh_req,
    output logic [1:0]          sh_kind,
    output logic [7:0]          sh_byte,
    output logic [4:0]          sh_cycles,
    output logic                sh_frame,
    output logic                cap_valid,
    output logic [2:0]          cap_idx,
    output logic [7:0]          cap_byte
);
    seq_state_e state_q, state_nx;
    logic [2:0] idx_q, idx_nx;
    logic [2:0] last_idx;
    logic [1:0] addr_sel;

    function automatic seq_state_e phase_after(seq_state_e from, cmd_word_t c);
        if (from == ST_OPCODE && c.addr_en)
            return ST_ADDR;
        if ((from == ST_OPCODE || from == ST_ADDR) && c.dummy != 5'd0)
            return ST_DUMMY;
        if ((from == ST_OPCODE || from == ST_ADDR || from == ST_DUMMY) && c.wr_en)
            return ST_WDATA;
        if (from != ST_RDATA && c.rd_en)
            return ST_RDATA;
        return ST_SETTLE;
    endfunction

    always_comb begin
        unique case (state_q)
            ST_ADDR:  last_idx = {1'b0, cmd.addr_len_m1};
            ST_WDATA: last_idx = cmd.wr_cnt_m1;
            ST_RDATA: last_idx = cmd.rd_cnt_m1;
            default:  last_idx = 3'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_nx;
            idx_q   <= idx_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        idx_nx   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_OPCODE;
                    idx_nx   = '0;
                end
            end
            ST_OPCODE, ST_ADDR, ST_DUMMY, ST_WDATA, ST_RDATA: begin
                if (sh_ack) begin
                    if (idx_q == last_idx) begin
                        state_nx = phase_after(state_q, cmd);
                        idx_nx   = '0;
                    end else begin
                        idx_nx = idx_q + 3'd1;
                    end
                end
            end
            ST_SETTLE: begin
                if (settled) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign addr_sel = cmd.addr_len_m1 - idx_q[1:0];

    always_comb begin
        sh_req    = 1'b0;
        sh_kind   = ITEM_TX;
        sh_byte   = 8'h00;
        sh_cycles = 5'd0;
        unique case (state_q)
            ST_OPCODE: begin
                sh_req  = 1'b1;
                sh_byte = cmd.opcode;
            end
            ST_ADDR: begin
                sh_req  = 1'b1;
                sh_byte = cmd_addr[{addr_sel, 3'b000} +: 8];
            end
            ST_DUMMY: begin
                sh_req    = 1'b1;
                sh_kind   = ITEM_DUMMY;
                sh_cycles = cmd.dummy;
            end
            ST_WDATA: begin
                sh_req  = 1'b1;
                sh_byte = wpay[{idx_q, 3'b000} +: 8];
            end
            ST_RDATA: begin
                sh_req  = 1'b1;
                sh_kind = ITEM_RX;
            end
            default: ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign arm       = (state_q == ST_SETTLE);
    assign sh_frame  = sh_req;
    assign cap_valid = (state_q == ST_RDATA) && sh_ack;
    assign cap_idx   = idx_q;
    assign cap_byte  = sh_rx_byte;

    // R11: offered item held until acknowledged
    a_r11_item_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_req && !sh_ack) |=> (sh_req && $stable(sh_kind) && $stable(sh_byte) && $stable(sh_cycles)));

    // R3: the opcode is always the first item
    a_r3_opcode_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sh_req && sh_kind == ITEM_TX && sh_byte == cmd.opcode));

    // R2: only a launch leaves idle
    a_r2_launch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/flcmd_engine.sv
module flcmd_engine
    import flcmd_pkg::*;
#(
    parameter int IDLE_SAMPLES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_waddr,
    input  logic [31:0] bus_wdata,
    input  logic [2:0]  bus_raddr,
    output logic [31:0] bus_rdata,
    output logic        sh_req,
    output logic [1:0]  sh_kind,
    output logic [7:0]  sh_byte,
    output logic [4:0]  sh_cycles,
    output logic        sh_frame,
    input  logic        sh_ack,
    input  logic [7:0]  sh_rx_byte,
    input  logic        ser_idle
);
    localparam int WORD_W = 32;

    logic              busy, arm, settled, start;
    logic              cap_valid;
    logic [2:0]        cap_idx;
    logic [7:0]        cap_byte;
    cmd_word_t         cmd;
    logic [WORD_W-1:0] cmd_addr;
    logic [2*WORD_W-1:0] wpay;

    flcmd_regs #(.WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .busy(busy), .cap_valid(cap_valid), .cap_idx(cap_idx), .cap_byte(cap_byte),
        .start(start), .cmd(cmd), .cmd_addr(cmd_addr), .wpay(wpay)
    );

    flcmd_seq #(.WORD_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .cmd(cmd), .cmd_addr(cmd_addr), .wpay(wpay),
        .sh_ack(sh_ack), .sh_rx_byte(sh_rx_byte), .settled(settled),
        .busy(busy), .arm(arm),
        .sh_req(sh_req), .sh_kind(sh_kind), .sh_byte(sh_byte),
        .sh_cycles(sh_cycles), .sh_frame(sh_frame),
        .cap_valid(cap_valid), .cap_idx(cap_idx), .cap_byte(cap_byte)
    );

    flcmd_idle_filt #(.IDLE_SAMPLES(IDLE_SAMPLES)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .arm(arm), .idle_in(ser_idle), .settled(settled)
    );

endmodule

// File: tb/tb_flcmd_engine.sv
`timescale 1ns/1ps
module tb_flcmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [2:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;
    logic        sh_req, sh_frame;
    logic [1:0]  sh_kind;
    logic [7:0]  sh_byte;
    logic [4:0]  sh_cycles;
    logic        sh_ack = 1'b0;
    logic [7:0]  sh_rx_byte = '0;
    logic        ser_idle = 1'b1;

    always #4 clk = ~clk;

    flcmd_engine dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .sh_req(sh_req), .sh_kind(sh_kind), .sh_byte(sh_byte),
        .sh_cycles(sh_cycles), .sh_frame(sh_frame),
        .sh_ack(sh_ack), .sh_rx_byte(sh_rx_byte), .ser_idle(ser_idle)
    );

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] bval;
        logic [4:0] cyc;
    } item_t;

    item_t       exp_q[$];
    int          checks = 0;
    int          errors = 0;
    int          rx_seq = 0;
    int          item_n = 0;
    logic [31:0] cur_ctrl;
    logic [63:0] exp_rd;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // monitor / serializer model: pops expected items and compares
    initial begin : monitor
        item_t  got, e;
        logic [7:0] rxv;
        forever begin
            @(negedge clk);
            if (sh_req === 1'b1) begin
                got = '{kind: sh_kind, bval: sh_byte, cyc: sh_cycles};
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected item", 64'(got), 64'(0));
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e, "R3 R4 R5 R6 R7 R8 item", 64'(got), 64'(e));
                end
                rxv = 8'hC0 + 8'(rx_seq);
                if (sh_kind == 2'd2) rx_seq++;
                for (int d = 0; d < item_n % 3; d++) @(negedge clk);
                sh_ack = 1'b1;
                sh_rx_byte = rxv;
                @(negedge clk);
                sh_ack = 1'b0;
                item_n++;
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_raddr = a;
        #1 d = bus_rdata;
    endtask

    task automatic push(input logic [1:0] k, input logic [7:0] b, input logic [4:0] cy);
        exp_q.push_back('{kind: k, bval: b, cyc: cy});
    endtask

    task automatic launch(input logic [31:0] ctrl, input logic [31:0] addr,
                          input logic [31:0] wlo, input logic [31:0] whi);
        int n;
        logic [63:0] wp;
        wp = {whi, wlo};
        bus_write(3'd1, addr);
        bus_write(3'd2, wlo);
        bus_write(3'd3, whi);
        push(2'd0, ctrl[31:24], 5'd0);
        if (ctrl[19]) begin
            n = int'(ctrl[17:16]) + 1;
            for (int i = 0; i < n; i++) push(2'd0, addr[8*(n-1-i) +: 8], 5'd0);
        end
        if (ctrl[11:7] != 0) push(2'd1, 8'd0, ctrl[11:7]);
        if (ctrl[15]) for (int k = 0; k <= int'(ctrl[14:12]); k++) push(2'd0, wp[8*k +: 8], 5'd0);
        exp_rd = '0;
        if (ctrl[23]) for (int k = 0; k <= int'(ctrl[22:20]); k++) begin
            push(2'd2, 8'd0, 5'd0);
            exp_rd[8*k +: 8] = 8'hC0 + 8'(rx_seq + k);
        end
        cur_ctrl = ctrl | 32'd1;
        bus_write(3'd0, cur_ctrl);
    endtask

    task automatic complete(input string tag);
        logic [31:0] v;
        int t;
        t = 0;
        bus_read(3'd0, v);
        while (v[1] && t < 3000) begin
            bus_read(3'd0, v);
            t++;
        end
        chk(v == {cur_ctrl[31:2], 2'b00}, {tag, " R2 ctrl readback"}, 64'(v), 64'({cur_ctrl[31:2], 2'b00}));
        chk(exp_q.size() == 0, {tag, " items consumed"}, 64'(exp_q.size()), 64'd0);
        bus_read(3'd4, v);
        chk(v == exp_rd[31:0], {tag, " R7 result lower"}, 64'(v), 64'(exp_rd[31:0]));
        bus_read(3'd5, v);
        chk(v == exp_rd[63:32], {tag, " R7 result upper"}, 64'(v), 64'(exp_rd[63:32]));
    endtask

    initial begin : driver
        logic [31:0] v;
        for (int i = 0; i < 4; i++) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            bus_read(3'(a), v);
            chk(v == 32'd0, "R1 register after reset", 64'(v), 64'd0);
        end
        chk(sh_req == 1'b0, "R1 sh_req after reset", 64'(sh_req), 64'd0);

        // R2 R3: opcode only
        launch(32'h0600_0000, 32'h0, 32'h0, 32'h0);
        complete("R3 opcode-only");

        // R7: 3-byte read, upper bytes zero
        launch({8'h9F, 1'b1, 3'd2, 20'h0}, 32'h0, 32'h0, 32'h0);
        complete("R7 short read");

        // R4 R6: 3-byte address, 5-byte write
        launch({8'h02, 4'b0001, 4'b1010, 4'b1100, 12'h0}, 32'h0012_3456, 32'h4433_2211, 32'h8877_6655);
        complete("R4 R6 addr3 write5");

        // R4 R5 R7: 4-byte address, 8 dummy clocks, 8-byte read
        launch({8'h0B, 1'b1, 3'd7, 4'b1011, 4'b0000, 5'd8, 7'h0}, 32'hA1B2_C3D4, 32'h0, 32'h0);
        complete("R5 addr4 dummy read8");

        // R8: write two then read one; R12 result writes ignored
        launch({8'h77, 1'b1, 3'd0, 4'b0000, 4'b1001, 12'h0}, 32'h0, 32'h0000_BEEF, 32'h0);
        complete("R8 write then read");
        bus_write(3'd4, 32'hFFFF_FFFF);
        bus_write(3'd5, 32'hFFFF_FFFF);
        bus_read(3'd4, v);
        chk(v == exp_rd[31:0], "R12 result lower write ignored", 64'(v), 64'(exp_rd[31:0]));
        bus_read(3'd5, v);
        chk(v == 32'd0, "R12 result upper write ignored", 64'(v), 64'd0);

        // R10: control write during a command
        launch({8'h3B, 1'b1, 3'd7, 4'b1011, 4'b0000, 5'd4, 7'h0}, 32'h0102_0304, 32'h0, 32'h0);
        for (int i = 0; i < 3; i++) @(negedge clk);
        bus_write(3'd0, 32'h1234_5679);
        complete("R10 busy write");
        for (int i = 0; i < 10; i++) @(negedge clk);
        chk(sh_req == 1'b0, "R10 no extra launch", 64'(sh_req), 64'd0);
        bus_read(3'd0, v);
        chk(v[1:0] == 2'b00, "R10 still idle", 64'(v[1:0]), 64'd0);

        // R9: idle filter with a dropout
        ser_idle = 1'b0;
        launch(32'hAB00_0000, 32'h0, 32'h0, 32'h0);
        while (exp_q.size() != 0) @(negedge clk);
        for (int i = 0; i < 6; i++) @(negedge clk);
        bus_raddr = 3'd0;
        #1 chk(bus_rdata[1] == 1'b1, "R9 busy while serializer active", 64'(bus_rdata[1]), 64'd1);
        @(negedge clk); ser_idle = 1'b1;
        @(negedge clk); ser_idle = 1'b1;
        @(negedge clk); ser_idle = 1'b0;
        @(negedge clk); ser_idle = 1'b1;
        @(negedge clk); ser_idle = 1'b1;
        @(negedge clk);
        #1 chk(bus_rdata[1] == 1'b1, "R9 busy after two idle samples", 64'(bus_rdata[1]), 64'd1);
        @(negedge clk);
        #1 chk(bus_rdata[1] == 1'b0, "R9 clear after three idle samples", 64'(bus_rdata[1]), 64'd0);

        finish_run();
    end

endmodule